// File: doc/BRIEF.md
# I2C Read Target with Address-Hold Clock Stretching

This block is a 7-bit-address I2C target that only serves master reads. It watches open-drain SCL and SDA through sampled inputs and pulls either line low through a drive-low enable. When a Start is followed by its own address with the R/W bit set to 1, the block acknowledges. It then shifts out one byte per transfer from a transmit buffer, most significant bit first. After every byte that is acknowledged it holds SCL low until host logic has loaded the next byte and released the clock.

With the hold option set, the block stops the bus as soon as it recognises a matching address, before the acknowledge bit. Host logic then decides the answer by writing the ACK data bit and releasing the clock. A set of host-side flags follows the transfer: buffer full, interrupt, acknowledge window, master acknowledge status, R/W and data/address. A master NACK ends the transfer without stretching, and a Stop returns the block to idle.

Top module: `i2c_hold_target`

## Requirements
- R1: The target samples eight bits MSB first on SCL rising edges after a Start: a 7-bit address then R/W. It acknowledges only when the address equals `own_addr` and R/W is 1. Any other byte gets no SDA drive, leaves every host flag unchanged, and the bus is ignored until the next Start.
- R2: With `hold_en` = 0, a matching address is acknowledged automatically. SDA is driven low from the 8th SCL falling edge to the 9th SCL falling edge.
- R3: With `hold_en` = 1, on the 8th falling edge of a matching address the block clears `clk_release`, holds SCL low and sets `irq`. During the 9th clock, SDA carries `ack_data` (0 = ACK, 1 = NACK). A `release_set` pulse sets `clk_release` and lets SCL go.
- R4: `ack_time` sets on the 8th SCL falling edge of a matched address or a transmitted byte. It clears on the following (9th) rising edge.
- R5: On a matching address, `rx_byte` holds the received {address, R/W} byte and `buf_full` sets. `buf_read` clears `buf_full`. `tx_load` sets it and wins over `buf_read` in the same cycle. It clears on the 8th falling edge of the byte being sent.
- R6: After any acknowledged read byte (address or data), `clk_release` clears and SCL is held low. After `release_set`, the target loads `tx_data` and shifts it out MSB first. SDA changes only while SCL is low.
- R7: The master's SDA level at the 9th rising edge of each sent byte is copied to `ack_stat` (0 = ACK). After a NACK, `clk_release` stays set, SCL is not held, and the target drives nothing.
- R8: `irq` sets on the 9th falling edge of every matched address byte and every sent byte, and also on the hold point of R3. It stays set until `irq_clear`.
- R9: `data_flag` is 0 after an address byte and 1 after a data byte. `rw_bit` holds the received R/W bit of the matched address.
- R10: After reset or a Stop the target is idle: no drive on either line, `clk_release` = 1, and the other flags are 0 after reset. A Stop in mid-address discards the partial byte, so the next Start begins a fresh address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| own_addr | input | 7 | Target address |
| hold_en | input | 1 | Stretch after a matching address for a host ACK decision |
| tx_load | input | 1 | Write `tx_data` into the transmit buffer |
| tx_data | input | 8 | Next byte to send |
| buf_read | input | 1 | Host has read `rx_byte` |
| irq_clear | input | 1 | Clear the interrupt flag |
| ackdt_write | input | 1 | Write `ackdt_value` into the ACK data bit |
| ackdt_value | input | 1 | ACK data value (0 = ACK) |
| release_set | input | 1 | Set the clock-release bit |
| rx_byte | output | 8 | Captured address and R/W byte |
| buf_full | output | 1 | Buffer-full flag |
| irq | output | 1 | Interrupt flag |
| ack_data | output | 1 | ACK data bit |
| ack_stat | output | 1 | Master acknowledge status |
| ack_time | output | 1 | Acknowledge-window flag |
| clk_release | output | 1 | Clock-release bit |
| rw_bit | output | 1 | Received R/W bit |
| data_flag | output | 1 | 1 after data byte, 0 after address |

## Verification
The bench builds the block with the default two-stage synchronizer. The five-clock settle window after each bus step therefore covers the input path plus the edge register. It sweeps `hold_en` at run time so that the automatic ACK, a host ACK and a host NACK after a stretch all occur. The sequences also reach master ACK and NACK of data bytes, a non-matching address, a write request to the own address and a Stop in mid-address. These show that clock holding, flag timing and the bit counter restart behave at each boundary.

// File: rtl/i2c_hold_pkg.sv
package i2c_hold_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 7;
    localparam int CNT_W  = $clog2(DATA_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_TXWAIT,
        ST_TX,
        ST_MACK
    } tgt_state_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic addr_cap;
        logic hold_grab;
        logic byte_end;
        logic stretch;
        logic tx_done;
    } ctl_ev_t;

    function automatic logic read_hit(input logic [DATA_W-1:0] b,
                                      input logic [ADDR_W-1:0] a);
        return (b[DATA_W-1:1] == a) && b[0];
    endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_hold_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [1:0] raw;
    logic [1:0] synced;
    logic       scl_q, sda_q;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [SYNC_STAGES-1:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) pipe <= '1;
            else     pipe <= {pipe[SYNC_STAGES-2:0], raw[g]};
        end
        assign synced[g] = pipe[SYNC_STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= synced[1];
            sda_q <= synced[0];
        end
    end

    always_comb begin
        ev.scl      = synced[1];
        ev.sda      = synced[0];
        ev.scl_rise = synced[1] & ~scl_q;
        ev.scl_fall = ~synced[1] & scl_q;
        ev.start    = synced[1] & scl_q & sda_q & ~synced[0];
        ev.stop     = synced[1] & scl_q & ~sda_q & synced[0];
    end
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import i2c_hold_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              hold_en,
    input  logic              ackdt,
    input  logic              clk_release,
    input  logic [DATA_W-1:0] tx_buf,
    output tgt_state_t        st,
    output ctl_ev_t           ctl,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rw_bit,
    output logic              data_flag,
    output logic              ack_stat,
    output logic              ack_time,
    output logic              sda_oe,
    output logic              scl_oe
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              addr_ack;

    assign addr_ack = hold_en ? ~ackdt : 1'b1;

    always_comb begin
        ctl.addr_cap  = (st == ST_ADDR) && ev.scl_fall && (cnt == LAST_BIT)
                        && read_hit(shreg, own_addr);
        ctl.hold_grab = ctl.addr_cap && hold_en;
        ctl.byte_end  = ((st == ST_AACK) || (st == ST_MACK)) && ev.scl_fall;
        ctl.stretch   = ctl.byte_end &&
                        (((st == ST_AACK) && addr_ack) || ((st == ST_MACK) && !ack_stat));
        ctl.tx_done   = (st == ST_TX) && ev.scl_fall && (cnt == LAST_TX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            rx_byte   <= '0;
            rw_bit    <= 1'b0;
            data_flag <= 1'b0;
            ack_stat  <= 1'b0;
            ack_time  <= 1'b0;
        end else if (ev.stop) begin
            st       <= ST_IDLE;
            ack_time <= 1'b0;
        end else if (ev.start) begin
            st       <= ST_ADDR;
            cnt      <= '0;
            ack_time <= 1'b0;
        end else begin
            case (st)
                ST_ADDR: begin
                    if (ev.scl_rise) begin
                        shreg <= {shreg[DATA_W-2:0], ev.sda};
                        cnt   <= cnt + 1'b1;
                    end else if (ev.scl_fall && (cnt == LAST_BIT)) begin
                        if (ctl.addr_cap) begin
                            rx_byte  <= shreg;
                            rw_bit   <= shreg[0];
                            ack_time <= 1'b1;
                            st       <= ST_AACK;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                ST_AACK: begin
                    if (ev.scl_rise) ack_time <= 1'b0;
                    else if (ev.scl_fall) begin
                        data_flag <= 1'b0;
                        st        <= addr_ack ? ST_TXWAIT : ST_IDLE;
                    end
                end
                ST_TXWAIT: begin
                    if (clk_release) begin
                        shreg <= tx_buf;
                        cnt   <= '0;
                        st    <= ST_TX;
                    end
                end
                ST_TX: begin
                    if (ev.scl_fall) begin
                        shreg <= {shreg[DATA_W-2:0], 1'b0};
                        cnt   <= cnt + 1'b1;
                        if (cnt == LAST_TX) begin
                            ack_time <= 1'b1;
                            st       <= ST_MACK;
                        end
                    end
                end
                ST_MACK: begin
                    if (ev.scl_rise) begin
                        ack_stat <= ev.sda;
                        ack_time <= 1'b0;
                    end else if (ev.scl_fall) begin
                        data_flag <= 1'b1;
                        st        <= ack_stat ? ST_IDLE : ST_TXWAIT;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign sda_oe = ((st == ST_AACK) && addr_ack) || ((st == ST_TX) && !shreg[DATA_W-1]);
    assign scl_oe = ((st == ST_AACK) || (st == ST_TXWAIT)) && !clk_release;

    assert_acktime_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_time) |-> $past(ev.scl_fall));
    assert_acktime_off_rise_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_time) |-> $past(ev.scl_rise || ev.start || ev.stop));
    assert_sda_moves_low_R6: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_TX) && ($past(st) == ST_TX) && !$stable(sda_oe)) |-> !ev.scl);
endmodule

// File: rtl/i2c_host_regs.sv
module i2c_host_regs
    import i2c_hold_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctl_ev_t           ctl,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              buf_read,
    input  logic              irq_clear,
    input  logic              ackdt_write,
    input  logic              ackdt_value,
    input  logic              release_set,
    output logic [DATA_W-1:0] tx_buf,
    output logic              buf_full,
    output logic              irq,
    output logic              ackdt,
    output logic              clk_release
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_buf      <= '0;
            buf_full    <= 1'b0;
            irq         <= 1'b0;
            ackdt       <= 1'b0;
            clk_release <= 1'b1;
        end else begin
            if (tx_load) tx_buf <= tx_data;

            if (ctl.addr_cap || tx_load)      buf_full <= 1'b1;
            else if (buf_read || ctl.tx_done) buf_full <= 1'b0;

            if (ctl.hold_grab || ctl.byte_end) irq <= 1'b1;
            else if (irq_clear)                irq <= 1'b0;

            if (ackdt_write) ackdt <= ackdt_value;

            if (ctl.hold_grab || ctl.stretch) clk_release <= 1'b0;
            else if (release_set)             clk_release <= 1'b1;
        end
    end

    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clear) |=> irq);
endmodule

// File: rtl/i2c_hold_target.sv
module i2c_hold_target
    import i2c_hold_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              hold_en,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              buf_read,
    input  logic              irq_clear,
    input  logic              ackdt_write,
    input  logic              ackdt_value,
    input  logic              release_set,
    output logic [DATA_W-1:0] rx_byte,
    output logic              buf_full,
    output logic              irq,
    output logic              ack_data,
    output logic              ack_stat,
    output logic              ack_time,
    output logic              clk_release,
    output logic              rw_bit,
    output logic              data_flag
);
    bus_ev_t           ev;
    ctl_ev_t           ctl;
    tgt_state_t        st;
    logic [DATA_W-1:0] tx_buf;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    i2c_target_fsm fsm_i (
        .clk(clk), .rst(rst), .ev(ev), .own_addr(own_addr), .hold_en(hold_en),
        .ackdt(ack_data), .clk_release(clk_release), .tx_buf(tx_buf),
        .st(st), .ctl(ctl), .rx_byte(rx_byte), .rw_bit(rw_bit),
        .data_flag(data_flag), .ack_stat(ack_stat), .ack_time(ack_time),
        .sda_oe(sda_oe), .scl_oe(scl_oe)
    );

    i2c_host_regs regs_i (
        .clk(clk), .rst(rst), .ctl(ctl), .tx_load(tx_load), .tx_data(tx_data),
        .buf_read(buf_read), .irq_clear(irq_clear), .ackdt_write(ackdt_write),
        .ackdt_value(ackdt_value), .release_set(release_set), .tx_buf(tx_buf),
        .buf_full(buf_full), .irq(irq), .ackdt(ack_data), .clk_release(clk_release)
    );

    assert_release_frees_R3: assert property (@(posedge clk) disable iff (rst)
        (release_set && !ctl.hold_grab && !ctl.stretch) |=> !scl_oe);
    assert_nack_no_hold_R7: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_MACK) && ev.scl_fall && ack_stat && !ev.start && !ev.stop)
        |=> (clk_release && !scl_oe && !sda_oe));
endmodule

// File: tb/i2c_hold_target_tb_top.sv
module i2c_hold_target_tb_top;
    localparam logic [6:0] OWN = 7'h5A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic m_scl_lo = 1'b0, m_sda_lo = 1'b0;
    logic hold_en = 1'b0, tx_load = 1'b0, buf_read = 1'b0, irq_clear = 1'b0;
    logic ackdt_write = 1'b0, ackdt_value = 1'b0, release_set = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic scl_oe, sda_oe, buf_full, irq, ack_data, ack_stat, ack_time;
    logic clk_release, rw_bit, data_flag;
    logic [7:0] rx_byte;
    wire scl_line = !(m_scl_lo || scl_oe);
    wire sda_line = !(m_sda_lo || sda_oe);

    i2c_hold_target dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN), .hold_en(hold_en),
        .tx_load(tx_load), .tx_data(tx_data), .buf_read(buf_read),
        .irq_clear(irq_clear), .ackdt_write(ackdt_write), .ackdt_value(ackdt_value),
        .release_set(release_set), .rx_byte(rx_byte), .buf_full(buf_full),
        .irq(irq), .ack_data(ack_data), .ack_stat(ack_stat), .ack_time(ack_time),
        .clk_release(clk_release), .rw_bit(rw_bit), .data_flag(data_flag)
    );

    int checks = 0, errors = 0;
    bit done = 0;
    bit m_irq, m_bf, m_rel = 1, m_at, m_sclo, m_sdao, m_df, m_as, m_ackdt;

    task automatic chk(input string req, input string nm, input logic [7:0] act,
                       input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, nm, act, exp);
        end
    endtask

    task automatic cmp_all(input string req);
        chk(req, "irq", irq, m_irq);
        chk(req, "buf_full", buf_full, m_bf);
        chk(req, "clk_release", clk_release, m_rel);
        chk(req, "ack_time", ack_time, m_at);
        chk(req, "scl_oe", scl_oe, m_sclo);
        chk(req, "sda_oe", sda_oe, m_sdao);
        chk(req, "data_flag", data_flag, m_df);
        chk(req, "ack_stat", ack_stat, m_as);
        chk(req, "ack_data", ack_data, m_ackdt);
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask
    task automatic set_scl(input bit lo); m_scl_lo = lo; settle(); endtask
    task automatic set_sda(input bit lo); m_sda_lo = lo; settle(); endtask

    task automatic host(input bit rd, input bit clr, input bit ld, input logic [7:0] d,
                        input bit rel);
        buf_read = rd; irq_clear = clr; tx_load = ld; tx_data = d; release_set = rel;
        @(negedge clk);
        buf_read = 0; irq_clear = 0; tx_load = 0; release_set = 0;
        settle();
    endtask

    task automatic write_ackdt(input bit v);
        ackdt_value = v; ackdt_write = 1;
        @(negedge clk);
        ackdt_write = 0;
        m_ackdt = v; m_sdao = hold_en && (m_sdao || m_sclo) ? !v : m_sdao;
        settle();
    endtask

    task automatic start_cond();
        set_sda(1); set_scl(1);
    endtask
    task automatic stop_cond();
        set_sda(1); set_scl(0); set_sda(0);
    endtask

    task automatic addr_phase(input logic [7:0] b, input bit hit);
        start_cond();
        for (int i = 7; i >= 0; i--) begin
            m_sda_lo = !b[i];
            settle();
            set_scl(0);
            set_scl(1);
            if (i == 0 && hit) begin
                m_bf = 1; m_at = 1;
                m_sdao = hold_en ? !m_ackdt : 1'b1;
                if (hold_en) begin m_irq = 1; m_rel = 0; m_sclo = 1; end
            end
            cmp_all(hit ? "R4" : "R1");
        end
        if (hit) chk("R5", "rx_byte", rx_byte, b);
        set_sda(0);
    endtask

    task automatic addr_ack(input bit hit, input bit host_nack);
        bit a;
        a = hit && (hold_en ? !host_nack : 1'b1);
        if (hit && hold_en) begin
            set_scl(0);
            chk("R3", "scl_line_held", scl_line, 1'b0);
            cmp_all("R3");
            write_ackdt(host_nack);
            cmp_all("R3");
            m_rel = 1; m_sclo = 0; m_at = 0;
            host(0, 0, 0, 8'h00, 1);
            chk("R3", "scl_line_free", scl_line, 1'b1);
            cmp_all("R3");
        end else begin
            set_scl(0);
            if (hit) m_at = 0;
            cmp_all(hit ? "R4" : "R1");
        end
        chk(hold_en ? "R3" : "R2", "ack_seen", !sda_line, a);
        set_scl(1);
        if (hit) begin
            m_irq = 1; m_sdao = 0; m_df = 0;
            if (a) begin m_rel = 0; m_sclo = 1; end
            chk("R9", "rw_bit", rw_bit, 1'b1);
        end
        cmp_all(hit ? "R8" : "R1");
    endtask

    task automatic tx_byte(input logic [7:0] d, input bit nack);
        m_bf = 1; m_irq = 0;
        host(1, 1, 1, d, 0);
        cmp_all("R5");
        m_rel = 1; m_sclo = 0; m_sdao = !d[7];
        host(0, 0, 0, 8'h00, 1);
        cmp_all("R6");
        for (int i = 7; i >= 0; i--) begin
            chk("R6", "sda_bit", sda_line, d[i]);
            set_scl(0);
            chk("R6", "sda_bit_high", sda_line, d[i]);
            set_scl(1);
            if (i > 0) m_sdao = !d[i-1];
            else begin m_sdao = 0; m_at = 1; m_bf = 0; end
            cmp_all(i > 0 ? "R6" : "R4");
        end
        set_sda(!nack);
        set_scl(0);
        m_at = 0; m_as = nack;
        cmp_all("R7");
        set_scl(1);
        m_irq = 1; m_df = 1;
        if (!nack) begin m_rel = 0; m_sclo = 1; end
        cmp_all(nack ? "R7" : "R9");
        set_sda(0);
        cmp_all("R6");
    endtask

    task automatic clean();
        m_irq = 0; m_bf = 0;
        host(1, 1, 0, 8'h00, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        settle();
        cmp_all("R10");

        // automatic ACK, two data bytes, master ACK then NACK
        addr_phase({OWN, 1'b1}, 1);
        addr_ack(1, 0);
        tx_byte(8'hA5, 0);
        tx_byte(8'h3C, 1);
        stop_cond();
        cmp_all("R7");
        clean();

        // hold with host ACK
        hold_en = 1;
        addr_phase({OWN, 1'b1}, 1);
        addr_ack(1, 0);
        tx_byte(8'h81, 1);
        stop_cond();
        clean();

        // hold with host NACK
        addr_phase({OWN, 1'b1}, 1);
        addr_ack(1, 1);
        cmp_all("R3");
        stop_cond();
        write_ackdt(0);
        clean();
        hold_en = 0;

        // other address, write request to own address
        addr_phase({OWN ^ 7'h01, 1'b1}, 0);
        addr_ack(0, 0);
        stop_cond();
        cmp_all("R1");
        addr_phase({OWN, 1'b0}, 0);
        addr_ack(0, 0);
        stop_cond();
        cmp_all("R1");

        // Stop in mid-address, then a fresh transfer
        start_cond();
        for (int i = 0; i < 3; i++) begin
            m_sda_lo = 1'b0; settle(); set_scl(0); set_scl(1);
        end
        stop_cond();
        cmp_all("R10");
        addr_phase({OWN, 1'b1}, 1);
        addr_ack(1, 0);
        tx_byte(8'h6E, 1);
        stop_cond();
        cmp_all("R10");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule